// File: doc/BRIEF.md
# Trap Entry and Return Stack Sequencer

This block is the control slice of an 8-bit processor that handles two events: entering a software trap and returning from one. It owns the 16-bit program counter, the 8-bit stack pointer and the 8-bit status register. It moves every multi-byte value through a single byte-wide synchronous memory port, one access per clock. Instruction fetch, decode and arithmetic live elsewhere. The surrounding core raises a one-cycle request and waits for the one-cycle completion strobe.

A trap entry saves the return address and then the status byte on a stack that grows downward inside page 0x01. It then sets the interrupt-mask bit and loads the program counter from a fixed two-byte vector. A trap return unwinds the same frame in the opposite order. The memory returns read data one clock after the read is issued, so each fetched byte is consumed one cycle after its request.

Top module: `trap_stack_seq`

## Requirements
- R1: After reset, pc is 0x0000, sp is 0xFF, status is 0x20, busy and done are low, and no memory access is issued.
- R2: A stack write goes to address {0x01, sp} and sp then drops by one. A stack read first raises sp by one and reads {0x01, sp+1}. Both wrap modulo 256.
- R3: On an entry request, three consecutive write cycles store trap_pc+2 (modulo 2^16), high byte first, then the low byte, then the status byte. The stored status byte has bit 4 and bit 5 forced to 1.
- R4: From the cycle after the status byte is written, status bit 2 (interrupt mask) is 1. All other status bits are unchanged by an entry.
- R5: An entry then reads 0xFFFE and 0xFFFF in consecutive cycles. The new pc is {byte at 0xFFFF, byte at 0xFFFE}.
- R6: A return request reads three stack bytes in turn: status first, then the pc low byte, then the pc high byte. The status register and pc take those values.
- R7: At most one memory access occurs per cycle. A byte that is read is used in the following cycle, and the last byte read is followed by one cycle with no access.
- R8: done is high for exactly one cycle, in the first cycle in which the final pc is visible. busy is low in that cycle. An entry shows done 7 cycles after the request edge, and a return 5 cycles after it. pc changes in no other cycle.
- R9: Requests that arrive while busy is high are ignored.
- R10: If both requests are high in the same idle cycle, the entry is taken.
- R11: Stack accesses wrap within page 0x01. A write with sp = 0x00 lands at 0x0100 and leaves sp = 0xFF. A read with sp = 0xFF reads 0x0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | One-cycle request to enter a trap |
| return_req | input | 1 | One-cycle request to return from a trap |
| trap_pc | input | 16 | Address of the trapping opcode, sampled with entry_req |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 16 | Memory address of the current access |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion strobe |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |

## Verification
The bench goes after three cases. The first is a stack pointer that crosses 0x00 and 0xFF in both directions. A design that wrapped out of page 0x01 would write or read 0x0200 or 0x00FF, and its frames would come back corrupted. The second is a trap address of 0xFFFE, whose return address wraps to 0x0000. A carry leaking into a wider adder would store a wrong high byte. The third is a return request pulsed in the middle of an entry, and both requests raised together. A sequencer that accepted the stray pulse would corrupt the stack pointer, and wrong priority would show a read where the first write should be. The bench also varies the vector and the status values so that a swapped byte order, a late interrupt-mask update or the use of read data one cycle early shows up as a wrong pc or status byte.

// File: rtl/tss_pkg.sv
package tss_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [AW-1:0] VEC_ADDR   = 16'hFFFE;
    localparam int            RET_OFFSET = 2;

    localparam int BIT_MASK_I = 2;
    localparam int BIT_SAVED  = 4;
    localparam int BIT_SPARE  = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_ST,
        S_VEC_LO,
        S_VEC_HI,
        S_POP_ST,
        S_POP_LO,
        S_POP_HI,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] pc;
        logic [AW-1:0] ret;
        logic [DW-1:0] sp;
        logic [DW-1:0] st;
        logic [DW-1:0] lo;
        logic          done;
    } seq_regs_t;

endpackage

// File: rtl/tss_stack_addr.sv
module tss_stack_addr
    import tss_pkg::*;
(
    input  logic [DW-1:0] sp,
    output logic [AW-1:0] push_addr,
    output logic [AW-1:0] pop_addr,
    output logic [DW-1:0] sp_dec,
    output logic [DW-1:0] sp_inc
);

    // Write at the current slot, then step down; step up, then read.
    always_comb begin
        sp_dec    = sp - DW'(1);
        sp_inc    = sp + DW'(1);
        push_addr = {STACK_PAGE, sp};
        pop_addr  = {STACK_PAGE, sp_inc};
    end

endmodule

// File: rtl/tss_status_fmt.sv
module tss_status_fmt
    import tss_pkg::*;
(
    input  logic [DW-1:0] st,
    output logic [DW-1:0] st_pushed,
    output logic [DW-1:0] st_after_entry
);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        localparam bit FORCE_SAVE = (b == BIT_SAVED) || (b == BIT_SPARE);
        localparam bit FORCE_MASK = (b == BIT_MASK_I);
        assign st_pushed[b]      = st[b] | FORCE_SAVE;
        assign st_after_entry[b] = st[b] | FORCE_MASK;
    end

endmodule

// File: rtl/trap_stack_seq.sv
module trap_stack_seq
    import tss_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h0000,
    parameter logic [DW-1:0] RESET_SP = 8'hFF,
    parameter logic [DW-1:0] RESET_ST = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          entry_req,
    input  logic          return_req,
    input  logic [AW-1:0] trap_pc,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] status
);

    seq_regs_t q, d;

    logic [AW-1:0] push_addr, pop_addr;
    logic [DW-1:0] sp_dec, sp_inc;
    logic [DW-1:0] st_pushed, st_after_entry;

    tss_stack_addr u_stack_addr (
        .sp        (q.sp),
        .push_addr (push_addr),
        .pop_addr  (pop_addr),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc)
    );

    tss_status_fmt u_status_fmt (
        .st             (q.st),
        .st_pushed      (st_pushed),
        .st_after_entry (st_after_entry)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_addr  = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = '0;

        unique case (q.state)
            S_IDLE: begin
                // Entry wins when both requests arrive together.
                if (entry_req) begin
                    d.ret   = trap_pc + AW'(RET_OFFSET);
                    d.state = S_PUSH_HI;
                end else if (return_req) begin
                    d.state = S_POP_ST;
                end
            end
            S_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = q.ret[AW-1:DW];
                d.sp      = sp_dec;
                d.state   = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = q.ret[DW-1:0];
                d.sp      = sp_dec;
                d.state   = S_PUSH_ST;
            end
            S_PUSH_ST: begin
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = st_pushed;
                d.sp      = sp_dec;
                d.st      = st_after_entry;
                d.state   = S_VEC_LO;
            end
            S_VEC_LO: begin
                mem_rd   = 1'b1;
                mem_addr = VEC_ADDR;
                d.state  = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_rd   = 1'b1;
                mem_addr = VEC_ADDR + AW'(1);
                d.lo     = mem_rdata;       // low vector byte from last cycle
                d.state  = S_FIN;
            end
            S_POP_ST: begin
                mem_rd   = 1'b1;
                mem_addr = pop_addr;
                d.sp     = sp_inc;
                d.state  = S_POP_LO;
            end
            S_POP_LO: begin
                mem_rd   = 1'b1;
                mem_addr = pop_addr;
                d.sp     = sp_inc;
                d.st     = mem_rdata;       // status byte
                d.state  = S_POP_HI;
            end
            S_POP_HI: begin
                mem_rd   = 1'b1;
                mem_addr = pop_addr;
                d.sp     = sp_inc;
                d.lo     = mem_rdata;       // pc low byte
                d.state  = S_FIN;
            end
            S_FIN: begin
                // Shared tail: high byte arrives now for both sequences.
                d.pc    = {mem_rdata, q.lo};
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, pc: RESET_PC, ret: '0, sp: RESET_SP,
                   st: RESET_ST, lo: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.state != S_IDLE);
    assign done   = q.done;
    assign pc     = q.pc;
    assign sp     = q.sp;
    assign status = q.st;

endmodule

// File: rtl/tss_checker.sv
module tss_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_wr,
    input logic        mem_rd,
    input logic        busy,
    input logic        done,
    input logic [15:0] pc,
    input logic [7:0]  sp,
    input logic [7:0]  status
);

    a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    a_r2_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr == {8'h01, sp});

    a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> sp == $past(sp) - 8'd1);

    a_r2_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] == 8'h01) |-> mem_addr[7:0] == sp + 8'd1);

    a_r2_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] == 8'h01) |=> sp == $past(sp) + 8'd1);

    a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(mem_wr)) |-> status[2]);

    a_r5_vector_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr == 16'hFFFE) |=> (mem_rd && mem_addr == 16'hFFFF));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_pc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> done);

endmodule

bind trap_stack_seq tss_checker u_tss_checker (.*);

// File: tb/test_trap_stack_seq.sv
module test_trap_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0;
    logic        return_req = 1'b0;
    logic [15:0] trap_pc = 16'h0000;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic        busy, done;
    logic [15:0] pc;
    logic [7:0]  sp, status;

    always #5 clk = ~clk;

    trap_stack_seq i_trap_stack_seq (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
        .trap_pc(trap_pc), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .pc(pc), .sp(sp), .status(status)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- memory: one copy driven by the design, one by the model
    bit [7:0] sim_mem [int];
    bit [7:0] ref_mem [int];

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] sim_rd(input logic [15:0] a);
        if (sim_mem.exists(int'(a))) return sim_mem[int'(a)];
        return fill(a);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return fill(a);
    endfunction

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        sim_mem[int'(a)] = v;
        ref_mem[int'(a)] = v;
    endtask

    always @(posedge clk) begin
        if (mem_wr) sim_mem[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= sim_rd(mem_addr);
    end

    // ---------------- reference model: expected snapshot per cycle
    typedef struct {
        bit          busy, rd, wr, done;
        logic [15:0] addr, pc;
        logic [7:0]  wdata, sp, st;
        string       tag;
    } snap_t;

    snap_t exp_q[$];
    logic [15:0] ref_pc = 16'h0000;
    logic [7:0]  ref_sp = 8'hFF;
    logic [7:0]  ref_st = 8'h20;

    function automatic snap_t mk(bit b, bit r, bit w, logic [15:0] a, logic [7:0] wd,
                                 logic [7:0] s, logic [15:0] p, logic [7:0] t,
                                 bit dn, string tg);
        snap_t x;
        x.busy = b; x.rd = r; x.wr = w; x.addr = a; x.wdata = wd;
        x.sp = s; x.pc = p; x.st = t; x.done = dn; x.tag = tg;
        return x;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_entry(input logic [15:0] op);
        logic [15:0] ret, npc;
        logic [7:0]  s0, s1, s2, s3, t1;
        ret = op + 16'd2;
        s0 = ref_sp; s1 = s0 - 8'd1; s2 = s0 - 8'd2; s3 = s0 - 8'd3;
        t1 = ref_st | 8'h04;
        exp_q.push_back(mk(1, 0, 1, {8'h01, s0}, ret[15:8], s0, ref_pc, ref_st, 0,
                           (s0 == 8'h00) ? "R11" : "R3"));
        exp_q.push_back(mk(1, 0, 1, {8'h01, s1}, ret[7:0], s1, ref_pc, ref_st, 0,
                           (s1 == 8'h00) ? "R11" : "R3"));
        exp_q.push_back(mk(1, 0, 1, {8'h01, s2}, ref_st | 8'h30, s2, ref_pc, ref_st, 0,
                           (s2 == 8'h00) ? "R11" : "R3"));
        ref_mem[int'({8'h01, s0})] = ret[15:8];
        ref_mem[int'({8'h01, s1})] = ret[7:0];
        ref_mem[int'({8'h01, s2})] = ref_st | 8'h30;
        exp_q.push_back(mk(1, 1, 0, 16'hFFFE, 8'h00, s3, ref_pc, t1, 0, "R4"));
        exp_q.push_back(mk(1, 1, 0, 16'hFFFF, 8'h00, s3, ref_pc, t1, 0, "R5"));
        exp_q.push_back(mk(1, 0, 0, 16'h0000, 8'h00, s3, ref_pc, t1, 0, "R7"));
        npc = {ref_rd(16'hFFFF), ref_rd(16'hFFFE)};
        exp_q.push_back(mk(0, 0, 0, 16'h0000, 8'h00, s3, npc, t1, 1, "R8"));
        ref_sp = s3; ref_st = t1; ref_pc = npc;
    endtask

    task automatic model_return();
        logic [7:0] s0, a1, a2, a3, stn, lo, hi;
        s0 = ref_sp; a1 = s0 + 8'd1; a2 = s0 + 8'd2; a3 = s0 + 8'd3;
        stn = ref_rd({8'h01, a1});
        lo  = ref_rd({8'h01, a2});
        hi  = ref_rd({8'h01, a3});
        exp_q.push_back(mk(1, 1, 0, {8'h01, a1}, 8'h00, s0, ref_pc, ref_st, 0,
                           (a1 == 8'h00) ? "R11" : "R6"));
        exp_q.push_back(mk(1, 1, 0, {8'h01, a2}, 8'h00, a1, ref_pc, ref_st, 0,
                           (a2 == 8'h00) ? "R11" : "R2"));
        exp_q.push_back(mk(1, 1, 0, {8'h01, a3}, 8'h00, a2, ref_pc, stn, 0,
                           (a3 == 8'h00) ? "R11" : "R6"));
        exp_q.push_back(mk(1, 0, 0, 16'h0000, 8'h00, a3, ref_pc, stn, 0, "R7"));
        exp_q.push_back(mk(0, 0, 0, 16'h0000, 8'h00, a3, {hi, lo}, stn, 1, "R8"));
        ref_sp = a3; ref_st = stn; ref_pc = {hi, lo};
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            snap_t e;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = mk(0, 0, 0, 16'h0000, 8'h00, ref_sp, ref_pc, ref_st, 0, "R1");
            chk(e.tag, "busy",   32'(busy),   32'(e.busy));
            chk(e.tag, "done",   32'(done),   32'(e.done));
            chk(e.tag, "mem_rd", 32'(mem_rd), 32'(e.rd));
            chk(e.tag, "mem_wr", 32'(mem_wr), 32'(e.wr));
            chk(e.tag, "sp",     32'(sp),     32'(e.sp));
            chk(e.tag, "pc",     32'(pc),     32'(e.pc));
            chk(e.tag, "status", 32'(status), 32'(e.st));
            if (e.rd || e.wr) chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.wr) chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.wdata));
            // R9: only an idle cycle accepts; R10: entry has priority.
            if (!e.busy) begin
                if (entry_req) model_entry(trap_pc);
                else if (return_req) model_return();
            end
        end
    end

    // ---------------- stimulus
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse(input bit en, input bit rt, input logic [15:0] op);
        @(posedge clk); #1;
        entry_req = en; return_req = rt; trap_pc = op;
        @(posedge clk); #1;
        entry_req = 1'b0; return_req = 1'b0;
    endtask

    initial begin
        poke(16'hFFFE, 8'h00);
        poke(16'hFFFF, 8'hC0);
        poke(16'h0100, 8'hC3);
        poke(16'h0101, 8'h34);
        poke(16'h0102, 8'h12);
        cyc(3); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset pc", 32'(pc), 32'h0000);
        chk("R1", "reset sp", 32'(sp), 32'hFF);
        chk("R1", "reset status", 32'(status), 32'h20);
        cyc(2);

        // R11: first read from sp=FF wraps to 0x0100; R6 restore.
        pulse(0, 1, 16'h0000);
        cyc(4); @(negedge clk);
        chk("R6", "pc after return", 32'(pc), 32'h1234);
        chk("R6", "status after return", 32'(status), 32'hC3);
        chk("R11", "sp after wrapping reads", 32'(sp), 32'h02);

        // R11: third write lands at 0x0100 with sp=00; R4 / R5.
        pulse(1, 0, 16'h2000);
        cyc(6); @(negedge clk);
        chk("R5", "pc from vector", 32'(pc), 32'hC000);
        chk("R4", "mask bit set", 32'(status), 32'hC7);
        chk("R11", "sp after wrapping writes", 32'(sp), 32'hFF);
        chk("R3", "stored status byte", 32'(sim_rd(16'h0100)), 32'hF3);

        // R9: return pulse during an entry is ignored.
        poke(16'hFFFE, 8'h80);
        poke(16'hFFFF, 8'h5E);
        pulse(1, 0, 16'h3000);
        pulse(0, 1, 16'h0000);
        cyc(4); @(negedge clk);
        chk("R9", "pc not restored by stray return", 32'(pc), 32'h5E80);
        chk("R9", "sp after entry only", 32'(sp), 32'hFC);

        // R3: return address wraps past 0xFFFF.
        pulse(1, 0, 16'hFFFE);
        @(negedge clk);
        chk("R3", "wrapped high byte", 32'(mem_wdata), 32'h00);
        @(negedge clk);
        chk("R3", "wrapped low byte", 32'(mem_wdata), 32'h00);
        cyc(5);

        // R10: both requests together start with a write.
        pulse(1, 1, 16'h4440);
        @(negedge clk);
        chk("R10", "entry taken first", 32'(mem_wr), 32'h1);
        cyc(6);

        // Deep nesting with varied vectors, crossing the page edge repeatedly.
        for (int k = 0; k < 90; k++) begin
            logic [15:0] op;
            op = 16'($urandom);
            poke(16'hFFFE, 8'($urandom));
            poke(16'hFFFF, 8'($urandom));
            pulse(1, 0, op);
            cyc(6);
        end
        for (int k = 0; k < 95; k++) begin
            pulse(0, 1, 16'h0000);
            cyc(4);
        end
        cyc(4);
        @(negedge clk);
        finished = 1;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending model cycles: actual %0d expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule